// File: doc/BRIEF.md
# Token-Initialised Elastic Pipeline

This block is a synchronous elastic datapath built from one-token buffer slots joined by a valid/ready handshake on a single clock. Two input streams each pass through their own chain of slots, meet in a combining stage that adds one token from each side, and the sums travel through a third chain to the output. Every slot is set at reset to be either empty or holding one token with a chosen value. A slot that holds a token at reset stands in for a register of the original circuit. An empty slot is pure pipelining.

The point of the block is that pipeline depth and token count are independent. Empty slots can be added to any chain to shorten logic paths. They raise latency, but the sequence of values seen at the output stays the same. Plain strobed samples enter through an ingress boundary that turns each accepted strobe into a token. An egress boundary turns each token it takes into a one-cycle output strobe with data.

Top module: `tok_pipe_top`

## Requirements
- R1: A slot holds at most one token, so a chain of N slots holds at most N tokens. With the output stalled from reset, each input accepts exactly as many tokens as the chains and the output chain have room for.
- R2: At reset, a slot whose bit is set in its chain's occupancy vector holds one token carrying its preset value. All other slots are empty. Preset tokens of a chain leave it before any input token, highest slot index first.
- R3: The combining stage emits a result only when both of its inputs hold a token, and it consumes exactly one token from each. The result is the sum of the two values modulo 2^8.
- R4: The output sequence is the preset tokens of the output chain, followed by the pairwise sums of the A-side sequence (its preset tokens, then its inputs) and the B-side sequence. The output sequence does not depend on how many empty slots any chain contains.
- R5: When the sink is always ready and both inputs strobe every cycle, one output strobe appears every cycle in steady state, and both input ready signals stay high.
- R6: When the sink is not ready, backpressure reaches the inputs (their ready signals drop once the slots are full). No token is lost, duplicated or altered, and a token waiting at the egress stays valid with stable data.
- R7: The egress raises `z_stb` for one cycle, one clock after it takes a token, and takes a token only in a cycle where `z_rdy` is high. With `z_rdy` low, `z_stb` stays low from the next cycle on.
- R8: The ingress turns each cycle with strobe and ready both high into exactly one token. A strobe while ready is low is not taken.

Top module parameters: DEPTH_A, DEPTH_B, DEPTH_O (slot counts), INIT_FULL_A/B/O (bit i set means slot i starts full, slot 0 nearest the input), and INIT_DATA_A/B/O (preset value of slot i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the preset tokens |
| a_stb | input | 1 | A-side sample present |
| a_dat | input | 8 | A-side sample value |
| a_rdy | output | 1 | A-side sample taken this cycle if strobed |
| b_stb | input | 1 | B-side sample present |
| b_dat | input | 8 | B-side sample value |
| b_rdy | output | 1 | B-side sample taken this cycle if strobed |
| z_rdy | input | 1 | Sink can take an output sample |
| z_stb | output | 1 | One-cycle output sample strobe |
| z_dat | output | 8 | Output sample value |

## Verification
The assertions assume that a strobed input sample is held, with its value, only for the cycles the bench offers it, and that `z_rdy` is an arbitrary level driven by the sink with no promise of progress. They also assume that the inputs change only away from the clock edge. The bench drives every input at the falling edge, so the combinational ready paths settle before the bench reads them. It advances its sample index only when strobe and ready were both high just before the rising edge. Sink readiness is either held at a fixed level or drawn at random each cycle, so long stalls and stalls of a single cycle both occur.

// File: rtl/tok_pkg.sv
package tok_pkg;

    localparam int unsigned TOK_W = 8;

    typedef logic [TOK_W-1:0] tok_data_t;

    typedef struct packed {
        logic      vld;
        tok_data_t dat;
    } tok_t;

    // Function evaluated by the combining stage: wrapping sum.
    function automatic tok_data_t tok_combine(tok_data_t x, tok_data_t y);
        return x + y;
    endfunction

endpackage

// File: rtl/elas_slot.sv
module elas_slot
    import tok_pkg::*;
#(
    parameter bit        INIT_FULL = 1'b0,
    parameter tok_data_t INIT_DATA = '0
) (
    input  logic clk,
    input  logic rst,
    input  tok_t up,
    output logic up_rdy,
    output tok_t dn,
    input  logic dn_rdy
);
    logic      full_q;
    tok_data_t data_q;

    // Accept when empty or when the held token leaves this cycle.
    assign up_rdy = !full_q || dn_rdy;
    assign dn     = '{vld: full_q, dat: data_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= INIT_FULL;
            data_q <= INIT_DATA;
        end else if (up_rdy) begin
            full_q <= up.vld;
            if (up.vld) data_q <= up.dat;
        end
    end
endmodule

// File: rtl/elas_chain.sv
module elas_chain
    import tok_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter logic [DEPTH-1:0]            INIT_FULL = '0,
    parameter logic [DEPTH-1:0][TOK_W-1:0] INIT_DATA = '0
) (
    input  logic clk,
    input  logic rst,
    input  tok_t up,
    output logic up_rdy,
    output tok_t dn,
    input  logic dn_rdy
);
    localparam int unsigned NLINK = DEPTH + 1;

    tok_t lnk [NLINK];
    logic rdy [NLINK];

    assign lnk[0]     = up;
    assign up_rdy     = rdy[0];
    assign dn         = lnk[DEPTH];
    assign rdy[DEPTH] = dn_rdy;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        elas_slot #(
            .INIT_FULL (INIT_FULL[i]),
            .INIT_DATA (INIT_DATA[i])
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .up     (lnk[i]),
            .up_rdy (rdy[i]),
            .dn     (lnk[i+1]),
            .dn_rdy (rdy[i+1])
        );
    end
endmodule

// File: rtl/elas_join.sv
module elas_join
    import tok_pkg::*;
(
    input  tok_t x,
    output logic x_rdy,
    input  tok_t y,
    output logic y_rdy,
    output tok_t z,
    input  logic z_rdy
);
    // Fires only when both sides hold a token; consumes one from each.
    assign z.vld = x.vld && y.vld;
    assign z.dat = tok_combine(x.dat, y.dat);
    assign x_rdy = z_rdy && y.vld;
    assign y_rdy = z_rdy && x.vld;
endmodule

// File: rtl/elas_egress.sv
module elas_egress
    import tok_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tok_t      tk,
    output logic      tk_rdy,
    input  logic      sink_rdy,
    output logic      out_stb,
    output tok_data_t out_dat
);
    assign tk_rdy = sink_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_stb <= 1'b0;
            out_dat <= '0;
        end else begin
            out_stb <= tk.vld && sink_rdy;
            if (tk.vld && sink_rdy) out_dat <= tk.dat;
        end
    end
endmodule

// File: rtl/tok_pipe_top.sv
module tok_pipe_top
    import tok_pkg::*;
#(
    parameter int unsigned DEPTH_A = 2,
    parameter int unsigned DEPTH_B = 1,
    parameter int unsigned DEPTH_O = 2,
    parameter logic [DEPTH_A-1:0]            INIT_FULL_A = '0,
    parameter logic [DEPTH_A-1:0][TOK_W-1:0] INIT_DATA_A = '0,
    parameter logic [DEPTH_B-1:0]            INIT_FULL_B = '0,
    parameter logic [DEPTH_B-1:0][TOK_W-1:0] INIT_DATA_B = '0,
    parameter logic [DEPTH_O-1:0]            INIT_FULL_O = '0,
    parameter logic [DEPTH_O-1:0][TOK_W-1:0] INIT_DATA_O = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_stb,
    input  logic [TOK_W-1:0] a_dat,
    output logic             a_rdy,
    input  logic             b_stb,
    input  logic [TOK_W-1:0] b_dat,
    output logic             b_rdy,
    input  logic             z_rdy,
    output logic             z_stb,
    output logic [TOK_W-1:0] z_dat
);
    tok_t a_in, b_in, a_tail, b_tail, j_out, eg_tok;
    logic a_tail_rdy, b_tail_rdy, j_out_rdy, eg_rdy;

    // Signals observed by the bound checker.
    logic      j_fire;
    logic      eg_vld;
    tok_data_t eg_dat;

    // Ingress boundary: each strobed sample becomes one token.
    assign a_in = '{vld: a_stb, dat: a_dat};
    assign b_in = '{vld: b_stb, dat: b_dat};

    elas_chain #(
        .DEPTH (DEPTH_A), .INIT_FULL (INIT_FULL_A), .INIT_DATA (INIT_DATA_A)
    ) u_chain_a (
        .clk (clk), .rst (rst),
        .up (a_in), .up_rdy (a_rdy),
        .dn (a_tail), .dn_rdy (a_tail_rdy)
    );

    elas_chain #(
        .DEPTH (DEPTH_B), .INIT_FULL (INIT_FULL_B), .INIT_DATA (INIT_DATA_B)
    ) u_chain_b (
        .clk (clk), .rst (rst),
        .up (b_in), .up_rdy (b_rdy),
        .dn (b_tail), .dn_rdy (b_tail_rdy)
    );

    elas_join u_join (
        .x (a_tail), .x_rdy (a_tail_rdy),
        .y (b_tail), .y_rdy (b_tail_rdy),
        .z (j_out),  .z_rdy (j_out_rdy)
    );

    elas_chain #(
        .DEPTH (DEPTH_O), .INIT_FULL (INIT_FULL_O), .INIT_DATA (INIT_DATA_O)
    ) u_chain_o (
        .clk (clk), .rst (rst),
        .up (j_out), .up_rdy (j_out_rdy),
        .dn (eg_tok), .dn_rdy (eg_rdy)
    );

    elas_egress u_egress (
        .clk (clk), .rst (rst),
        .tk (eg_tok), .tk_rdy (eg_rdy),
        .sink_rdy (z_rdy),
        .out_stb (z_stb), .out_dat (z_dat)
    );

    assign j_fire = j_out.vld && j_out_rdy;
    assign eg_vld = eg_tok.vld;
    assign eg_dat = eg_tok.dat;
endmodule

// File: rtl/tok_pipe_chk.sv
module tok_pipe_chk
    import tok_pkg::*;
#(
    parameter int unsigned DEPTH_A = 2,
    parameter int unsigned DEPTH_B = 1,
    parameter int unsigned DEPTH_O = 2,
    parameter logic [DEPTH_A-1:0] INIT_FULL_A = '0,
    parameter logic [DEPTH_B-1:0] INIT_FULL_B = '0,
    parameter logic [DEPTH_O-1:0] INIT_FULL_O = '0
) (
    input logic      clk,
    input logic      rst,
    input logic      a_stb,
    input logic      a_rdy,
    input logic      b_stb,
    input logic      b_rdy,
    input logic      j_fire,
    input logic      eg_vld,
    input tok_data_t eg_dat,
    input logic      z_rdy,
    input logic      z_stb
);
    int occ_a, occ_b, occ_o;

    // Token bookkeeping from boundary handshakes only.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_a <= $countones(INIT_FULL_A);
            occ_b <= $countones(INIT_FULL_B);
            occ_o <= $countones(INIT_FULL_O);
        end else begin
            occ_a <= occ_a + int'(a_stb && a_rdy) - int'(j_fire);
            occ_b <= occ_b + int'(b_stb && b_rdy) - int'(j_fire);
            occ_o <= occ_o + int'(j_fire) - int'(eg_vld && z_rdy);
        end
    end

    a_r1_a_cap: assert property (@(posedge clk) disable iff (rst)
        occ_a >= 0 && occ_a <= int'(DEPTH_A));
    a_r1_b_cap: assert property (@(posedge clk) disable iff (rst)
        occ_b >= 0 && occ_b <= int'(DEPTH_B));
    a_r1_o_cap: assert property (@(posedge clk) disable iff (rst)
        occ_o >= 0 && occ_o <= int'(DEPTH_O));
    a_r3_join_both: assert property (@(posedge clk) disable iff (rst)
        j_fire |-> (occ_a > 0 && occ_b > 0));
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (eg_vld && !z_rdy) |=> (eg_vld && $stable(eg_dat)));
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !z_rdy |=> !z_stb);
endmodule

bind tok_pipe_top tok_pipe_chk #(
    .DEPTH_A (DEPTH_A), .DEPTH_B (DEPTH_B), .DEPTH_O (DEPTH_O),
    .INIT_FULL_A (INIT_FULL_A), .INIT_FULL_B (INIT_FULL_B), .INIT_FULL_O (INIT_FULL_O)
) u_chk (
    .clk (clk), .rst (rst),
    .a_stb (a_stb), .a_rdy (a_rdy),
    .b_stb (b_stb), .b_rdy (b_rdy),
    .j_fire (j_fire), .eg_vld (eg_vld), .eg_dat (eg_dat),
    .z_rdy (z_rdy), .z_stb (z_stb)
);

// File: tb/sim_tok_pipe_top.sv
`timescale 1ns/1ps
module sim_tok_pipe_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       a_stb [2], a_rdy [2], b_stb [2], b_rdy [2];
    logic       z_rdy [2], z_stb [2];
    logic [7:0] a_dat [2], b_dat [2], z_dat [2];

    int errors = 0, checks = 0;
    int ia [2], ib [2], oidx [2], zcnt [2];
    bit done = 0;

    // Stimulus table: {a value, b value}, walked cyclically by sample index.
    localparam logic [15:0] VEC [16] = '{
        16'h0102, 16'hFF01, 16'h8080, 16'h0000, 16'h7F01, 16'h3355, 16'hAA55, 16'h10F0,
        16'hFE03, 16'h4242, 16'h0F0F, 16'hC001, 16'h2468, 16'h9999, 16'h01FF, 16'h5A5A};

    // Shallow instance: A has a preset token 0x11, output has preset 0x55.
    tok_pipe_top #(
        .DEPTH_A (2), .INIT_FULL_A (2'b10), .INIT_DATA_A ({8'h11, 8'h00}),
        .DEPTH_B (1), .INIT_FULL_B (1'b0),  .INIT_DATA_B (8'h00),
        .DEPTH_O (2), .INIT_FULL_O (2'b01), .INIT_DATA_O ({8'h00, 8'h55})
    ) u0 (
        .clk (clk), .rst (rst),
        .a_stb (a_stb[0]), .a_dat (a_dat[0]), .a_rdy (a_rdy[0]),
        .b_stb (b_stb[0]), .b_dat (b_dat[0]), .b_rdy (b_rdy[0]),
        .z_rdy (z_rdy[0]), .z_stb (z_stb[0]), .z_dat (z_dat[0])
    );

    // Same tokens with extra empty slots on every path.
    tok_pipe_top #(
        .DEPTH_A (5), .INIT_FULL_A (5'b00100),
        .INIT_DATA_A ({8'h00, 8'h00, 8'h11, 8'h00, 8'h00}),
        .DEPTH_B (3), .INIT_FULL_B (3'b000), .INIT_DATA_B ('0),
        .DEPTH_O (4), .INIT_FULL_O (4'b0100),
        .INIT_DATA_O ({8'h00, 8'h55, 8'h00, 8'h00})
    ) u1 (
        .clk (clk), .rst (rst),
        .a_stb (a_stb[1]), .a_dat (a_dat[1]), .a_rdy (a_rdy[1]),
        .b_stb (b_stb[1]), .b_dat (b_dat[1]), .b_rdy (b_rdy[1]),
        .z_rdy (z_rdy[1]), .z_stb (z_stb[1]), .z_dat (z_dat[1])
    );

    function automatic logic [7:0] a_val(int k); return VEC[k % 16][15:8]; endfunction
    function automatic logic [7:0] b_val(int k); return VEC[k % 16][7:0];  endfunction

    // Reference sequence from the requirements (R2, R3, R4).
    function automatic logic [7:0] exp_out(int j);
        logic [7:0] av;
        if (j == 0) return 8'h55;
        av = (j == 1) ? 8'h11 : a_val(j - 2);
        return av + b_val(j - 1);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode: 0 sink stalled, 1 sink ready, 2 random. rs: random strobes.
    task automatic step(int mode, bit rs, int lim, bit stall_chk);
        bit fa [2], fb [2];
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            if (stall_chk) chk(z_stb[d] == 1'b0, "R7 stb while stalled", int'(z_stb[d]), 0);
            if (z_stb[d]) begin
                chk(z_dat[d] == exp_out(oidx[d]), (oidx[d] == 0) ? "R2 preset first" : "R3,R4 seq",
                    int'(z_dat[d]), int'(exp_out(oidx[d])));
                oidx[d]++;
                zcnt[d]++;
            end
        end
        for (int d = 0; d < 2; d++) begin
            z_rdy[d] = (mode == 2) ? (($urandom % 4) != 0) : (mode == 1);
            a_stb[d] = (ia[d] < lim) && (!rs || $urandom % 2 == 0);
            b_stb[d] = (ib[d] < lim) && (!rs || $urandom % 2 == 0);
            a_dat[d] = a_val(ia[d]);
            b_dat[d] = b_val(ib[d]);
        end
        #1;
        for (int d = 0; d < 2; d++) begin
            fa[d] = a_stb[d] && a_rdy[d];
            fb[d] = b_stb[d] && b_rdy[d];
        end
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            if (fa[d]) ia[d]++;
            if (fb[d]) ib[d]++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int z0 [2];
        for (int d = 0; d < 2; d++) begin
            a_stb[d] = 0; b_stb[d] = 0; a_dat[d] = 0; b_dat[d] = 0; z_rdy[d] = 0;
            ia[d] = 0; ib[d] = 0; oidx[d] = 0; zcnt[d] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // Reset state (R2)
        for (int d = 0; d < 2; d++) begin
            chk(z_stb[d] == 1'b0, "R2 reset z_stb", int'(z_stb[d]), 0);
            chk(a_rdy[d] && b_rdy[d], "R2 reset ready", int'({a_rdy[d], b_rdy[d]}), 3);
        end

        // Output stalled from reset: capacity (R1), refused strobes (R8)
        for (int c = 0; c < 20; c++) step(0, 0, 1000, c > 0);
        chk(ia[0] == 2 && ib[0] == 2, "R1 capacity u0", ia[0] * 256 + ib[0], 2 * 256 + 2);
        chk(ia[1] == 7 && ib[1] == 6, "R1 capacity u1", ia[1] * 256 + ib[1], 7 * 256 + 6);
        chk(!a_rdy[0] && !b_rdy[0], "R8 no accept when not ready", int'({a_rdy[0], b_rdy[0]}), 0);

        // Sustained rate (R5)
        for (int c = 0; c < 40; c++) begin
            if (c == 20) for (int d = 0; d < 2; d++) z0[d] = zcnt[d];
            step(1, 0, 1000, 0);
            if (c >= 20) for (int d = 0; d < 2; d++)
                chk(a_rdy[d] && b_rdy[d], "R5 ready held", int'({a_rdy[d], b_rdy[d]}), 3);
        end
        for (int d = 0; d < 2; d++)
            chk(zcnt[d] - z0[d] == 20, "R5 one per cycle", zcnt[d] - z0[d], 20);

        // Random backpressure and strobes (R6)
        for (int c = 0; c < 300; c++) step(2, 1, 300, 0);

        // Long stall: backpressure reaches the inputs (R6, R7)
        for (int c = 0; c < 16; c++) step(0, 0, 340, c > 0);
        for (int d = 0; d < 2; d++)
            chk(!a_rdy[d] && !b_rdy[d], "R6 backpressure", int'({a_rdy[d], b_rdy[d]}), 0);

        // Drain (R6, R8): every sample appears exactly once
        for (int c = 0; c < 800; c++) step(1, 0, 340, 0);
        for (int d = 0; d < 2; d++) begin
            chk(ia[d] == 340 && ib[d] == 340, "R8 inputs taken", ia[d], 340);
            chk(oidx[d] == 341, "R6 output count", oidx[d], 341);
        end
        chk(oidx[0] == oidx[1], "R4 depth independent count", oidx[1], oidx[0]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule